// File: doc/BRIEF.md
# Serial Memory Slave with Page Buffer

This block is the two-wire serial slave that fronts a 256-byte nonvolatile store. The store is modelled as an on-chip register array. The bus master can write one byte or a short burst that stays inside a 4-byte page. It can read at the internal address counter, read from an address it chooses first, and keep reading across any number of bytes. SCL and SDA arrive already synchronised to the system clock. The block answers by pulling SDA low. Three strap inputs fill in the low bits of the slave address, so up to eight copies can share one bus.

Write data is not placed in the array while it is received. It is held in a small page buffer. The programming cycle begins on the STOP that closes a write carrying data. During that cycle a busy flag is high for a parameterised number of clocks, and the slave does not acknowledge its address. The buffered bytes are committed to the array together when the cycle ends.

Top module: `eep_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits are 1010 followed by strap bits 2..0. Bit 0 of that byte is 1 for a read and 0 for a write. For any other address the slave never pulls SDA low until the next START.
- R2: In a write, the byte after the address byte is the word address and the next byte is data. Each of these bytes is acknowledged. A STOP after one data byte programs that byte at the word address.
- R3: Further data bytes before STOP fill a 4-byte page. Only word-address bits 1..0 advance, so the fifth byte lands back in the slot of the first byte and replaces it. Bits 7..2 never change during the load.
- R4: A STOP that ends a write with at least one data byte raises busy for exactly WR_CYCLES clocks. While busy is high, the slave leaves its own address unacknowledged.
- R5: A STOP after a write that has no data byte (word address only) does not raise busy and programs nothing. It still loads the address counter with the word address.
- R6: A START, repeated or fresh, that arrives before the STOP discards the buffered write bytes. No programming cycle follows and the array is unchanged.
- R7: A read that is not preceded by a word address returns the byte at the internal address counter. After a page load the counter holds the page base with bits 1..0 one past the last slot written.
- R8: A write of the word address with no data, followed by a repeated START and a read, returns the byte at that word address.
- R9: During a read the full 8-bit counter advances after each byte sent and wraps from 255 to 0. A master acknowledge requests the next byte. A master NACK ends the transfer.
- R10: After reset, SDA is released, busy is low, every byte of the array is zero and the address counter is zero.
- R11: The slave changes its SDA pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level (resolved bus) |
| strap_i | input | 3 | Low three bits of the slave address |
| sda_pull_o | output | 1 | High to pull the SDA line low |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
A wrong internal state shows up on SDA within one byte time. A stale address counter or a wrong page slot changes the next data bit read back. A buffer that was not cleared turns up as an unexpected busy pulse on the STOP that follows. A wrong programming timer shows as a busy pulse of the wrong length, counted to the clock at the port. A wrong address match shows as an ACK bit with the wrong level on the ninth clock of the address byte.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int BYTE_W     = 8;
    localparam int SLOT_W     = 2;
    localparam int PAGE_BYTES = 1 << SLOT_W;
    localparam int PAGE_W     = BYTE_W - SLOT_W;
    localparam int DEPTH      = 1 << BYTE_W;
    localparam int BIT_CNT_W  = 4;
    localparam logic [3:0] DEV_FAMILY = 4'b1010;

    // Word address split into page number and slot inside the page.
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [SLOT_W-1:0] slot;
    } waddr_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_WADDR,
        S_WADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_TX,
        S_MACK
    } ctl_state_t;

    function automatic logic dev_hit(input logic [BYTE_W-1:0] b, input logic [2:0] strap);
        return b[BYTE_W-1:1] == {DEV_FAMILY, strap};
    endfunction

    // Advance only the slot bits: page loads wrap inside the page.
    function automatic waddr_t slot_next(input waddr_t a);
        waddr_t r;
        r      = a;
        r.slot = a.slot + 1'b1;
        return r;
    endfunction

    // Full-width advance used while reading.
    function automatic waddr_t linear_next(input waddr_t a);
        return waddr_t'(a + 1'b1);
    endfunction

endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/eep_store.sv
module eep_store
    import eep_pkg::*;
#(
    parameter int WR_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              wr_en_i,
    input  waddr_t            wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  waddr_t            rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              busy_o
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [BYTE_W-1:0]     mem  [DEPTH];
    logic [BYTE_W-1:0]     pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    logic [PAGE_W-1:0]     pbase;
    logic [CNT_W-1:0]      tmr;
    logic                  commit;

    assign busy_o    = (tmr != '0);
    assign commit    = (tmr == CNT_W'(1));
    assign rd_data_o = mem[rd_addr_i];

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr   <= '0;
            pmask <= '0;
            pbase <= '0;
        end else if (busy_o) begin
            tmr <= tmr - 1'b1;
            if (commit) pmask <= '0;
        end else if (stop_i) begin
            if (|pmask) tmr <= CNT_W'(WR_CYCLES);
        end else if (start_i) begin
            pmask <= '0;
        end else if (wr_en_i) begin
            pbase                 <= wr_addr_i.page;
            pmask[wr_addr_i.slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i && !busy_o) pbuf[wr_addr_i.slot] <= wr_data_i;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam int SLI = i % PAGE_BYTES;
        localparam int PGI = i / PAGE_BYTES;
        always_ff @(posedge clk) begin
            if (rst) mem[i] <= '0;
            else if (commit && pmask[SLI] && (pbase == PGI[PAGE_W-1:0])) mem[i] <= pbuf[SLI];
        end
    end

    AST_START_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (pmask == '0)); // R6
    AST_BUSY_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ($past(stop_i) && ($past(pmask) != '0))); // R5

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output waddr_t            addr_o,
    output logic              wr_en_o,
    output waddr_t            wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              sda_pull_o
);
    ctl_state_t           st;
    logic [BYTE_W-1:0]    sr;
    logic [BIT_CNT_W-1:0] bcnt;
    waddr_t               addr;
    logic                 rw;
    logic                 mack;

    assign addr_o = addr;

    always_ff @(posedge clk) begin
        wr_en_o <= 1'b0;
        if (rst) begin
            st         <= S_IDLE;
            sr         <= '0;
            bcnt       <= '0;
            addr       <= '0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            sda_pull_o <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
        end else if (start_det) begin
            st         <= S_DEV;
            bcnt       <= '0;
            sda_pull_o <= 1'b0;
        end else if (stop_det) begin
            st         <= S_IDLE;
            sda_pull_o <= 1'b0;
        end else begin
            case (st)
                S_DEV, S_WADDR, S_WDATA: begin
                    if (scl_rise) begin
                        sr   <= {sr[BYTE_W-2:0], sda_i};
                        bcnt <= bcnt + 1'b1;
                    end else if (scl_fall && bcnt == BIT_CNT_W'(BYTE_W)) begin
                        bcnt <= '0;
                        case (st)
                            S_DEV: begin
                                if (dev_hit(sr, strap_i) && !busy_i) begin
                                    sda_pull_o <= 1'b1;
                                    rw         <= sr[0];
                                    st         <= S_DEV_ACK;
                                end else begin
                                    st <= S_IDLE;
                                end
                            end
                            S_WADDR: begin
                                addr       <= waddr_t'(sr);
                                sda_pull_o <= 1'b1;
                                st         <= S_WADDR_ACK;
                            end
                            default: begin
                                wr_en_o    <= 1'b1;
                                wr_addr_o  <= addr;
                                wr_data_o  <= sr;
                                addr       <= slot_next(addr);
                                sda_pull_o <= 1'b1;
                                st         <= S_WDATA_ACK;
                            end
                        endcase
                    end
                end
                S_DEV_ACK: begin
                    if (scl_fall) begin
                        if (rw) begin
                            sr         <= rd_data_i;
                            sda_pull_o <= ~rd_data_i[BYTE_W-1];
                            addr       <= linear_next(addr);
                            bcnt       <= '0;
                            st         <= S_TX;
                        end else begin
                            sda_pull_o <= 1'b0;
                            st         <= S_WADDR;
                        end
                    end
                end
                S_WADDR_ACK, S_WDATA_ACK: begin
                    if (scl_fall) begin
                        sda_pull_o <= 1'b0;
                        st         <= S_WDATA;
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (bcnt == BIT_CNT_W'(BYTE_W - 1)) begin
                            sda_pull_o <= 1'b0;
                            st         <= S_MACK;
                        end else begin
                            sr         <= {sr[BYTE_W-2:0], 1'b0};
                            sda_pull_o <= ~sr[BYTE_W-2];
                            bcnt       <= bcnt + 1'b1;
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_i;
                    end else if (scl_fall) begin
                        if (mack) begin
                            sr         <= rd_data_i;
                            sda_pull_o <= ~rd_data_i[BYTE_W-1];
                            addr       <= linear_next(addr);
                            bcnt       <= '0;
                            st         <= S_TX;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (rst)
        (st == S_DEV_ACK) |-> !busy_i); // R4
    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (addr.page == wr_addr_o.page)); // R3
    AST_READ_STEP: assert property (@(posedge clk) disable iff (rst)
        (st == S_TX && $past(st) != S_TX) |-> (addr == waddr_t'($past(addr) + 1'b1))); // R9

endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
    import eep_pkg::*;
#(
    parameter int WR_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_pull_o,
    output logic       busy_o
);
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    waddr_t            cur_addr;
    logic              wr_en;
    waddr_t            wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;

    eep_bus_cond u_cond (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sda_i      (sda_i),
        .strap_i    (strap_i),
        .busy_i     (busy_o),
        .rd_data_i  (rd_data),
        .addr_o     (cur_addr),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .sda_pull_o (sda_pull_o)
    );

    eep_store #(.WR_CYCLES(WR_CYCLES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_det),
        .stop_i    (stop_det),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (cur_addr),
        .rd_data_o (rd_data),
        .busy_o    (busy_o)
    );

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !scl_i); // R11

endmodule

// File: tb/test_eep_i2c_slave.sv
module test_eep_i2c_slave;
    localparam int WRC = 300;
    localparam int Q   = 4;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEVW  = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEVR  = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_pull;
    logic busy;

    assign sda_bus = sda_m & ~sda_pull;
    always #4 clk = ~clk;

    eep_i2c_slave #(.WR_CYCLES(WRC)) i_eep_i2c_slave (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .strap_i    (STRAP),
        .sda_pull_o (sda_pull),
        .busy_o     (busy)
    );

    int errs = 0;
    int checks = 0;
    int viol = 0;
    bit seen_pull = 1'b0;
    logic pull_prev = 1'b0;
    logic [7:0] model [256];
    int maddr = 0;
    logic [7:0] pay [8];

    // R11 monitor: the pull may only rise while SCL is low.
    always @(negedge clk) begin
        if (!rst && sda_pull && !pull_prev && scl) viol++;
        if (sda_pull) seen_pull = 1'b1;
        pull_prev = sda_pull;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; tk(Q);
        scl = 1'b1;   tk(Q);
        sda_m = 1'b0; tk(Q);
        scl = 1'b0;   tk(Q);
    endtask

    task automatic i2c_stop(output int blen);
        sda_m = 1'b0; tk(Q);
        scl = 1'b1;   tk(Q);
        sda_m = 1'b1;
        blen = 0;
        for (int k = 0; k < WRC + 50; k++) begin
            @(negedge clk);
            if (busy) blen++;
            else break;
        end
        tk(Q);
    endtask

    task automatic stop_nowait;
        sda_m = 1'b0; tk(Q);
        scl = 1'b1;   tk(Q);
        sda_m = 1'b1; tk(Q);
    endtask

    task automatic wbit(input bit b);
        sda_m = b;  tk(Q);
        scl = 1'b1; tk(Q);
        scl = 1'b0; tk(Q);
    endtask

    task automatic wbyte(input logic [7:0] v, output bit ack);
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        sda_m = 1'b1; tk(Q);
        scl = 1'b1;   tk(2);
        ack = !sda_bus;
        tk(Q - 2);
        scl = 1'b0;   tk(Q);
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tk(Q);
            scl = 1'b1;   tk(2);
            v[i] = sda_bus;
            tk(Q - 2);
            scl = 1'b0;   tk(Q);
        end
        wbit(!give_ack);
    endtask

    // Write word address wa and n payload bytes; commit=1 ends with STOP.
    task automatic write_seq(input logic [7:0] wa, input int n, input bit commit, input string req);
        bit ack;
        int bl;
        i2c_start;
        wbyte(DEVW, ack); chk(ack, "R1", ack, 1);
        wbyte(wa, ack);   chk(ack, req, ack, 1);
        for (int k = 0; k < n; k++) begin
            wbyte(pay[k], ack); chk(ack, req, ack, 1);
        end
        maddr = {wa[7:2], 2'(wa[1:0] + 2'(n))};
        if (commit) begin
            i2c_stop(bl);
            if (n > 0) begin
                for (int k = 0; k < n; k++) model[{wa[7:2], 2'(wa[1:0] + 2'(k))}] = pay[k];
                chk(bl == WRC, "R4", bl, WRC);
            end else begin
                chk(bl == 0, "R5", bl, 0);
            end
        end
    endtask

    // Read n bytes; wa < 0 reads at the current counter.
    task automatic read_seq(input int wa, input int n, input string req, output int bl);
        bit ack;
        logic [7:0] v;
        if (wa >= 0) begin
            i2c_start;
            wbyte(DEVW, ack); chk(ack, "R8", ack, 1);
            wbyte(8'(wa), ack); chk(ack, "R8", ack, 1);
            maddr = wa;
        end
        i2c_start;
        wbyte(DEVR, ack); chk(ack, "R1", ack, 1);
        for (int k = 0; k < n; k++) begin
            rbyte(k != n - 1, v);
            chk(v == model[maddr], req, v, model[maddr]);
            maddr = (maddr + 1) % 256;
        end
        i2c_stop(bl);
    endtask

    initial begin
        bit ack;
        int bl;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        tk(5);
        rst = 1'b0;
        tk(2);
        chk(!sda_pull, "R10", sda_pull, 0);
        chk(!busy, "R10", busy, 0);

        // R10/R7: current read after reset at counter zero
        read_seq(-1, 2, "R10", bl);

        // R1: foreign address is ignored entirely
        seen_pull = 1'b0;
        i2c_start;
        wbyte(8'hA2, ack);
        wbyte(8'h00, ack);
        i2c_stop(bl);
        chk(!seen_pull, "R1", seen_pull, 0);

        // R2: byte write
        pay[0] = 8'hA5;
        write_seq(8'h12, 1, 1'b1, "R2");

        // R4: address NACK while programming
        pay[0] = 8'h5A;
        write_seq(8'h20, 1, 1'b0, "R2");
        model[8'h20] = 8'h5A;
        stop_nowait;
        chk(busy, "R4", busy, 1);
        i2c_start;
        wbyte(DEVW, ack);
        chk(!ack, "R4", ack, 0);
        stop_nowait;
        for (int k = 0; k < 2 * WRC && busy; k++) tk(1);

        // R8: random read of both bytes written
        read_seq(8'h12, 1, "R8", bl);
        read_seq(8'h20, 1, "R2", bl);

        // R3: five bytes from slot 1 wrap inside the page
        pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33; pay[3] = 8'h44; pay[4] = 8'h55;
        write_seq(8'h41, 5, 1'b1, "R3");
        read_seq(8'h40, 5, "R3", bl);

        // R7: counter after page load points one past the last slot
        pay[0] = 8'hC1; pay[1] = 8'hC2; pay[2] = 8'hC3;
        write_seq(8'h42, 3, 1'b1, "R3");
        read_seq(-1, 1, "R7", bl);

        // R5: word address only, then current read from it
        model[8'h90] = 8'h00;
        write_seq(8'h90, 0, 1'b1, "R5");
        read_seq(-1, 1, "R7", bl);

        // R6: repeated START cancels the buffered byte
        pay[0] = 8'h77;
        write_seq(8'h80, 1, 1'b0, "R6");
        read_seq(-1, 1, "R6", bl);
        chk(bl == 0, "R6", bl, 0);
        read_seq(8'h80, 1, "R6", bl);

        // R9: sequential read across 255 -> 0
        pay[0] = 8'h3C;
        write_seq(8'hFF, 1, 1'b1, "R2");
        pay[0] = 8'h9E;
        write_seq(8'h00, 1, 1'b1, "R2");
        read_seq(8'hFE, 4, "R9", bl);
        read_seq(-1, 1, "R9", bl);

        chk(viol == 0, "R11", viol, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule